// File: doc/BRIEF.md
# Key Wakeup Interrupt Controller

This block watches three byte-wide pin groups, named D, H and J here, and latches a flag bit for every pin that shows an active edge. Each pin also has an enable bit. A group raises its interrupt request while any of its flags is set together with the matching enable. Groups D and H treat only a falling edge as active. In group J, a polarity bit on each pin selects a rising or a falling edge. The request from group D is merged with an external interrupt line, and it passes on only while a shared external-interrupt enable is high.

Software reaches the flags, the enables and the J polarity bits through a byte-wide register port. The port has a 3-bit address, a write strobe and a combinational read. Flags are cleared by writing 1 to them. During normal running, each pin passes through a synchronizer before its edge is detected. In stop mode the clock may be halted. A separate combinational path then compares each raw pin with the last level the block sampled, so an active edge on an enabled pin raises the wake output without any clock edge.

Top module: `keywake_ctrl`

## Requirements
- R1: In run mode, a pin change that is applied after clock edge k sets the pin's flag after edge k+3 and not earlier. Pins in groups D and H count only a 1-to-0 change as active.
- R2: In group J, a polarity bit of 1 makes a 0-to-1 change active on that pin, and a polarity bit of 0 makes a 1-to-0 change active. All polarity bits are 0 after reset.
- R3: irq_h and irq_j are high exactly when their group has some bit with both flag and enable set. irq_d equals irq_en AND (ext_irq OR the same condition for group D).
- R4: Writing a flag register clears each flag whose write-data bit is 1 and leaves flags whose write-data bit is 0 unchanged. If an edge sets a flag on the same clock edge as the clear, the flag stays set.
- R5: Register map: address 0 holds the D flags, 1 the D enables, 2 the H flags, 3 the H enables, 4 the J flags, 5 the J enables and 6 the J polarity bits. Address 7 reads 0. Bit i of each register belongs to pin i. After reset every register reads 0.
- R6: Writing the polarity register does not set a J flag by itself. A J edge that would set its flag on the same clock edge as a polarity write is discarded.
- R7: When stop_mode is 1, an active change on a pin, measured against the level last sampled, raises wake at once without a clock edge. This holds only if the pin's enable is 1, and for group D only if irq_en is also 1. A pin whose enable is 0 does not raise wake.
- R8: wake is high whenever irq_d, irq_h or irq_j is high.
- R9: A flag is set by its edge whatever the state of its enable bit. The enable only gates the request.
- R10: The sampled pin history resets to all ones, so pins that are held high through reset set no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_mode | input | 1 | High while the system is in stop mode; enables the unclocked wake path |
| irq_en | input | 1 | Shared external-interrupt enable that gates the group D request |
| ext_irq | input | 1 | External interrupt request, merged into irq_d |
| pin_d | input | 8 | Group D pin levels (falling edge active) |
| pin_h | input | 8 | Group H pin levels (falling edge active) |
| pin_j | input | 8 | Group J pin levels (edge chosen per pin) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq_d | output | 1 | Group D request merged with ext_irq and gated by irq_en |
| irq_h | output | 1 | Group H request |
| irq_j | output | 1 | Group J request |
| wake | output | 1 | Combined wake request, including the stop-mode path |

## Verification
The edge detector is driven from a table of before-and-after pin bytes. The table covers single falling bits, pure rising changes on the falling-only groups, bytes with many bits changing, an unchanged byte, and group J with polarity all falling, all rising and split by nibble. Together these separate the wrong edge direction, a polarity bit applied to the wrong pin, and a flag set by a level rather than by a change. Directed sequences then place a clear write or a polarity write on exactly the edge where a detected change lands. They also stop the clock in stop mode and show that wake responds only to enabled pins.

// File: rtl/kwu_pkg.sv
package kwu_pkg;
  localparam int unsigned KW_W      = 8;
  localparam int unsigned KW_GROUPS = 3;
  localparam int unsigned KW_AW     = 3;

  typedef logic [KW_W-1:0] kw_vec_t;

  typedef enum logic [KW_AW-1:0] {
    A_FLAG_D = 3'd0, A_EN_D = 3'd1,
    A_FLAG_H = 3'd2, A_EN_H = 3'd3,
    A_FLAG_J = 3'd4, A_EN_J = 3'd5,
    A_POL_J  = 3'd6, A_NONE = 3'd7
  } kw_addr_e;

  // Active-edge hits per pin: rise bit 1 = rising edge, 0 = falling edge.
  function automatic kw_vec_t kw_edge_hits(kw_vec_t prev, kw_vec_t cur, kw_vec_t rise);
    return (rise & ~prev & cur) | (~rise & prev & ~cur);
  endfunction

  // Write-one-to-clear with set priority.
  function automatic kw_vec_t kw_flag_next(kw_vec_t flag, kw_vec_t clr, kw_vec_t hit);
    return (flag & ~clr) | hit;
  endfunction
endpackage

// File: rtl/kwu_sync.sv
module kwu_sync
  import kwu_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  kw_vec_t pin_i,
  output kw_vec_t level_o,
  output kw_vec_t hist_o
);
  kw_vec_t chain_q [STAGES];
  kw_vec_t hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
      hist_q <= '1;
    end else begin
      chain_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      hist_q <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign hist_o  = hist_q;
endmodule

// File: rtl/kwu_group.sv
module kwu_group
  import kwu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  kw_vec_t pin_i,
  input  kw_vec_t rise_i,
  input  logic    mute_i,
  input  logic    flag_wr_i,
  input  logic    en_wr_i,
  input  kw_vec_t wdata_i,
  output kw_vec_t flag_o,
  output kw_vec_t en_o,
  output kw_vec_t hit_o,
  output kw_vec_t async_hit_o,
  output logic    req_o
);
  kw_vec_t level, hist, flag_q, en_q, clr;

  kwu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .level_o (level),
    .hist_o  (hist)
  );

  // Clocked path: synchronized level against its history.
  assign hit_o = mute_i ? '0 : kw_edge_hits(hist, level, rise_i);
  // Unclocked path: raw pin against the last sampled level.
  assign async_hit_o = kw_edge_hits(hist, pin_i, rise_i);
  assign clr = flag_wr_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= kw_flag_next(flag_q, clr, hit_o);
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign req_o  = |(flag_q & en_q);
endmodule

// File: rtl/keywake_ctrl.sv
module keywake_ctrl
  import kwu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_mode,
  input  logic             irq_en,
  input  logic             ext_irq,
  input  logic [KW_W-1:0]  pin_d,
  input  logic [KW_W-1:0]  pin_h,
  input  logic [KW_W-1:0]  pin_j,
  input  logic             reg_wr,
  input  logic [KW_AW-1:0] reg_addr,
  input  logic [KW_W-1:0]  reg_wdata,
  output logic [KW_W-1:0]  reg_rdata,
  output logic             irq_d,
  output logic             irq_h,
  output logic             irq_j,
  output logic             wake
);
  localparam int unsigned NG    = KW_GROUPS;
  localparam int          D_IDX = 0;
  localparam int          H_IDX = 1;
  localparam int          J_IDX = 2;

  logic [NG-1:0][KW_W-1:0] pins, rise, flag_q, en_q, hit_q, ahit;
  logic [NG-1:0]           grp_req, stop_hit;
  kw_vec_t                 pol_q;
  logic                    pol_wr, stop_wake;

  assign pins   = {pin_j, pin_h, pin_d};
  assign rise   = {pol_q, {KW_W{1'b0}}, {KW_W{1'b0}}};
  assign pol_wr = reg_wr && (reg_addr == A_POL_J);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic flag_wr, en_wr;
    assign flag_wr = reg_wr && (reg_addr == KW_AW'(2 * g));
    assign en_wr   = reg_wr && (reg_addr == KW_AW'(2 * g + 1));

    kwu_group #(.SYNC_STAGES(SYNC_STAGES)) u_grp (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pins[g]),
      .rise_i      (rise[g]),
      .mute_i      ((g == J_IDX) ? pol_wr : 1'b0),
      .flag_wr_i   (flag_wr),
      .en_wr_i     (en_wr),
      .wdata_i     (reg_wdata),
      .flag_o      (flag_q[g]),
      .en_o        (en_q[g]),
      .hit_o       (hit_q[g]),
      .async_hit_o (ahit[g]),
      .req_o       (grp_req[g])
    );

    assign stop_hit[g] = |(en_q[g] & ahit[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_wr) pol_q <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_POL_J) reg_rdata = pol_q;
    else begin
      for (int g = 0; g < NG; g++) begin
        if (reg_addr == KW_AW'(2 * g))     reg_rdata = flag_q[g];
        if (reg_addr == KW_AW'(2 * g + 1)) reg_rdata = en_q[g];
      end
    end
  end

  assign irq_d     = irq_en & (ext_irq | grp_req[D_IDX]);
  assign irq_h     = grp_req[H_IDX];
  assign irq_j     = grp_req[J_IDX];
  assign stop_wake = stop_mode & ((irq_en & stop_hit[D_IDX]) | stop_hit[H_IDX] | stop_hit[J_IDX]);
  assign wake      = irq_d | irq_h | irq_j | stop_wake;
endmodule

// File: rtl/keywake_ctrl_chk.sv
module keywake_ctrl_chk
  import kwu_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          irq_en,
  input logic                          irq_d,
  input logic                          irq_h,
  input logic                          irq_j,
  input logic                          wake,
  input logic                          reg_wr,
  input logic [KW_AW-1:0]              reg_addr,
  input logic [KW_W-1:0]               reg_wdata,
  input logic [KW_GROUPS-1:0][KW_W-1:0] flag_q,
  input logic [KW_GROUPS-1:0][KW_W-1:0] hit_q
);
  // R3: group D request is blocked while the shared enable is low
  a_r3_irqd_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_d);

  // R8: any group request reaches the wake output
  a_r8_wake_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_d || irq_h || irq_j) |-> wake);

  // R6: a polarity write leaves the J flags as they were
  a_r6_pol_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_POL_J) |=> (flag_q[2] == $past(flag_q[2])));

  for (genvar g = 0; g < KW_GROUPS; g++) begin : g_chk
    // R1: a detected edge is latched on the next clock edge
    a_r1_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q[g] != '0) |=> ((flag_q[g] & $past(hit_q[g])) == $past(hit_q[g])));

    // R4: written ones clear flags that no edge sets in the same cycle
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == KW_AW'(2 * g) && ((hit_q[g] & reg_wdata) == '0))
      |=> ((flag_q[g] & $past(reg_wdata)) == '0));
  end
endmodule

bind keywake_ctrl keywake_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_en    (irq_en),
  .irq_d     (irq_d),
  .irq_h     (irq_h),
  .irq_j     (irq_j),
  .wake      (wake),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .flag_q    (flag_q),
  .hit_q     (hit_q)
);

// File: tb/sim_keywake_ctrl.sv
`timescale 1ns/1ps
module sim_keywake_ctrl;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       stop_mode = 1'b0, irq_en = 1'b0, ext_irq = 1'b0;
  logic [7:0] pin_d = 8'hFF, pin_h = 8'hFF, pin_j = 8'hFF;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_d, irq_h, irq_j, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = clk_run ? ~clk : 1'b0;

  keywake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .irq_en(irq_en), .ext_irq(ext_irq),
    .pin_d(pin_d), .pin_h(pin_h), .pin_j(pin_j),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_d(irq_d), .irq_h(irq_h), .irq_j(irq_j), .wake(wake)
  );

  // group, polarity, start pins, next pins, expected flags
  typedef struct packed {
    logic [1:0] grp;
    logic [7:0] pol;
    logic [7:0] start;
    logic [7:0] nxt;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 8'h00, 8'hFF, 8'hFE, 8'h01},
    '{2'd0, 8'h00, 8'hFE, 8'hFF, 8'h00},
    '{2'd1, 8'h00, 8'hFF, 8'h0F, 8'hF0},
    '{2'd1, 8'h00, 8'h00, 8'hFF, 8'h00},
    '{2'd2, 8'h00, 8'hFF, 8'h5A, 8'hA5},
    '{2'd2, 8'hFF, 8'h00, 8'h3C, 8'h3C},
    '{2'd2, 8'hF0, 8'hAA, 8'h55, 8'h5A},
    '{2'd0, 8'h00, 8'hA5, 8'hA5, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_grp(input logic [1:0] g, input logic [7:0] v);
    case (g)
      2'd0: pin_d = v;
      2'd1: pin_h = v;
      default: pin_j = v;
    endcase
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R5, R10: reset values, idle-high pins leave no flags
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R5/R10 reset reg %0d", a), v, 8'h00);
    end
    check("R5 reset outputs", {4'h0, irq_d, irq_h, irq_j, wake}, 8'h00);

    // R1, R2: table of edge patterns
    for (int k = 0; k < 8; k++) begin
      wr(3'd6, VECS[k].pol);
      set_grp(VECS[k].grp, VECS[k].start);
      tick(4);
      wr({VECS[k].grp, 1'b0}, 8'hFF);
      set_grp(VECS[k].grp, VECS[k].nxt);
      tick(3);
      rd({VECS[k].grp, 1'b0}, v);
      check($sformatf("R1/R2 vector %0d", k), v, VECS[k].exp);
    end
    wr(3'd6, 8'h00);
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF);

    // R1: latency of the clocked path
    pin_h = 8'hFF; tick(4); wr(3'd2, 8'hFF);
    pin_h = 8'hFE;
    tick(2); rd(3'd2, v); check("R1 flag not yet set", v, 8'h00);
    tick(1); rd(3'd2, v); check("R1 flag set after third edge", v, 8'h01);

    // R9, R3: flag set with enable off, enable gates request
    check("R9 request off while disabled", {7'h0, irq_h}, 8'h00);
    wr(3'd3, 8'h01);
    check("R3 irq_h with flag and enable", {6'h0, irq_h, wake}, 8'h03);
    wr(3'd3, 8'h00);

    // R4: write-one-to-clear
    wr(3'd2, 8'h00); rd(3'd2, v); check("R4 zero write keeps flag", v, 8'h01);
    wr(3'd2, 8'h01); rd(3'd2, v); check("R4 one write clears flag", v, 8'h00);
    pin_h = 8'hFC;
    tick(2);
    wr(3'd2, 8'h02);
    rd(3'd2, v); check("R4 edge wins over clear", v, 8'h02);
    wr(3'd2, 8'hFF);

    // R3: group D gating and external line merge
    irq_en = 1'b0;
    wr(3'd1, 8'h01);
    pin_d = 8'hFF; tick(4); wr(3'd0, 8'hFF);
    pin_d = 8'hFE; tick(3);
    check("R3 irq_d blocked by irq_en", {6'h0, irq_d, wake}, 8'h00);
    irq_en = 1'b1; #1;
    check("R3 irq_d passes with irq_en", {6'h0, irq_d, wake}, 8'h03);
    wr(3'd0, 8'h01);
    check("R3 irq_d low after clear", {7'h0, irq_d}, 8'h00);
    ext_irq = 1'b1; #1;
    check("R3 ext_irq merged", {6'h0, irq_d, wake}, 8'h03);
    ext_irq = 1'b0; wr(3'd1, 8'h00);

    // R6: polarity writes
    pin_j = 8'h00; tick(4); wr(3'd4, 8'hFF);
    wr(3'd6, 8'hFF); tick(3);
    rd(3'd4, v); check("R6 polarity change sets no flag", v, 8'h00);
    wr(3'd6, 8'h00);
    pin_j = 8'hFF; tick(4); wr(3'd4, 8'hFF);
    pin_j = 8'hFE; tick(2);
    wr(3'd6, 8'h00);
    tick(2); rd(3'd4, v); check("R6 edge on polarity write dropped", v, 8'h00);
    pin_j = 8'hFF; tick(3);
    rd(3'd4, v); check("R2 rising ignored when falling selected", v, 8'h00);

    // R7: stop-mode wake with the clock halted
    pin_h = 8'hFF; tick(4); wr(3'd2, 8'hFF);
    wr(3'd3, 8'h04);
    stop_mode = 1'b1;
    clk_run = 1'b0;
    #10;
    check("R7 no wake before edge", {7'h0, wake}, 8'h00);
    pin_h = 8'hF7; #1;
    check("R7 disabled pin gives no wake", {7'h0, wake}, 8'h00);
    pin_h = 8'hF3; #1;
    check("R7 enabled pin wakes without clock", {7'h0, wake}, 8'h01);
    clk_run = 1'b1;
    stop_mode = 1'b0;
    tick(4);
    check("R7 flag request after restart", {6'h0, irq_h, wake}, 8'h03);
    wr(3'd3, 8'h00); wr(3'd2, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule